// File: doc/BRIEF.md
# Duplicate-Result Register Sharing Tracker

This block sits beside the physical register file of an out-of-order core and records which physical register already holds each live result value. When an instruction finishes executing, its result value and the tag of the register that was allocated for it are presented on a lookup port. If some live register already holds the same value, the block reports that register's tag so the rename logic can point the destination at it and give back the freshly allocated one. Otherwise the value and the new tag are recorded so that later producers of the same value can share that register.

Sharing means that one physical register can back several logical mappings. The block therefore keeps a small saturating use count per physical register. Rename-time mappings raise it and retirement-time releases lower it. A remap moves one use from the fresh register to the shared one. When a count drops to zero, a one-cycle pulse on the free vector tells the free list that the register is available again. When a count reaches its ceiling, that register stops taking part in sharing.

Top module: `dedup_reuse_tracker`

## Requirements
- R1: A lookup presented in cycle t produces `rsp_valid`=1 in cycle t+1. On a hit, `rsp_hit`=1 and `rsp_tag` is the tag recorded with the matching value.
- R2: On a miss, `rsp_hit`=0 and `rsp_tag` equals the lookup's own tag. The pair is recorded if the table has an empty slot and the tag's updated count is between 1 and the ceiling minus 1. A later lookup of the same value then hits with that tag.
- R3: When every table slot is occupied at the start of the cycle, a missing value is not recorded, so a later lookup of it misses again.
- R4: The use counts are CNT_W bits wide (3 by default, ceiling 7). In one cycle, a map adds 1 to its tag, an unmap subtracts 1 from its tag, and a hit adds 1 to the matched tag and subtracts 1 from the lookup's own tag. The net change is applied and the result is clamped to the range 0 to the ceiling.
- R5: Bit i of `free_vec` is 1 for exactly one cycle, in cycle t+1, when the count of register i goes from nonzero in cycle t to zero. This includes the fresh register given up on a hit.
- R6: The entry of a register whose count becomes zero is removed in that same cycle, so no later lookup returns that tag.
- R7: The entry of a register whose count reaches the ceiling is removed in that same cycle. Lookups of its value miss from then on, and the tag never re-enters the table through its own entry.
- R8: A lookup in the same cycle as an unmap that takes the matching register's count from 1 to 0, with no map of that register in that cycle, misses.
- R9: While `rst_n` is low, all outputs are 0, all counts are 0 and the table is empty.
- R10: No value is ever held in two table slots at once, so each recorded value maps to exactly one tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup of an executed result |
| lk_value | input | DATA_W | Result value |
| lk_tag | input | TAG_W | Register allocated for this result |
| map_valid | input | 1 | A logical register was mapped onto a physical one |
| map_tag | input | TAG_W | Physical register being mapped |
| unmap_valid | input | 1 | A mapping was released |
| unmap_tag | input | TAG_W | Physical register whose mapping was released |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Value already held by a live register |
| rsp_tag | output | TAG_W | Shared tag on a hit, own tag on a miss |
| free_vec | output | NUM_PREG | One-cycle pulses of registers returned to the free list |

## Verification
Every result of this block is registered exactly once. The lookup response and the free pulses for a cycle-t stimulus are due in cycle t+1, while table and count changes first affect a lookup made in cycle t+1. The bench drives inputs on the falling edge and steps a behavioural model at the same time. It compares all outputs at the next falling edge, one rising edge after the stimulus. Directed sequences cover remap, release, saturation, table-full and same-cycle release. A long random stream then exercises overlapping updates to the same register.

// File: rtl/dedup_pkg.sv
package dedup_pkg;
   // smallest legal configuration limits shared by the tracker
   localparam int unsigned DEDUP_MIN_CNT_W = 2;
   localparam int unsigned DEDUP_MIN_PREGS = 2;
   // offset that keeps the per-cycle count sum non-negative (two decrements max)
   localparam int unsigned DEDUP_DEC_MAX   = 2;
endpackage

// File: rtl/dedup_ref_counters.sv
module dedup_ref_counters
   import dedup_pkg::*;
#(
   parameter int unsigned NUM_PREG = 16,
   parameter int unsigned CNT_W    = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_PREG-1:0]                inc_a,
   input  logic [NUM_PREG-1:0]                inc_b,
   input  logic [NUM_PREG-1:0]                dec_a,
   input  logic [NUM_PREG-1:0]                dec_b,
   output logic [NUM_PREG-1:0][CNT_W-1:0]     cnt_q,
   output logic [NUM_PREG-1:0][CNT_W-1:0]     cnt_nxt,
   output logic [NUM_PREG-1:0]                free_q
);
   localparam int unsigned SUM_W   = CNT_W + 2;
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   for (genvar i = 0; i < NUM_PREG; i++) begin : g_cnt
      logic [SUM_W-1:0] sum_off;

      // offset sum: count + increments + 2 - decrements, never negative
      always_comb begin
         sum_off = {2'b00, cnt_q[i]} + SUM_W'(inc_a[i]) + SUM_W'(inc_b[i])
                 + SUM_W'(DEDUP_DEC_MAX) - SUM_W'(dec_a[i]) - SUM_W'(dec_b[i]);
         if (sum_off < SUM_W'(DEDUP_DEC_MAX))
            cnt_nxt[i] = '0;
         else if (sum_off > SUM_W'(CNT_MAX + DEDUP_DEC_MAX))
            cnt_nxt[i] = CNT_W'(CNT_MAX);
         else
            cnt_nxt[i] = CNT_W'(sum_off - SUM_W'(DEDUP_DEC_MAX));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q[i]  <= '0;
            free_q[i] <= 1'b0;
         end else begin
            cnt_q[i]  <= cnt_nxt[i];
            free_q[i] <= (cnt_q[i] != '0) && (cnt_nxt[i] == '0);
         end
      end
   end
endmodule

// File: rtl/dedup_value_cam.sv
module dedup_value_cam #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_PREG = 16,
   parameter int unsigned TAG_W    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [DATA_W-1:0]                srch_value,
   input  logic [NUM_PREG-1:0]              block_vec,
   input  logic [NUM_PREG-1:0]              drop_vec,
   input  logic                             ins_req,
   input  logic [TAG_W-1:0]                 ins_tag,
   output logic                             match,
   output logic [TAG_W-1:0]                 match_tag,
   output logic [DEPTH-1:0]                 slot_valid,
   output logic [DEPTH-1:0][DATA_W-1:0]     slot_value,
   output logic [DEPTH-1:0][TAG_W-1:0]      slot_tag
);
   localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]  hit_vec;
   logic              free_found;
   logic [SLOT_W-1:0] free_idx;

   for (genvar j = 0; j < DEPTH; j++) begin : g_match
      assign hit_vec[j] = slot_valid[j] && (slot_value[j] == srch_value)
                          && !block_vec[slot_tag[j]];
   end

   // values are unique in the table, so at most one bit of hit_vec is set
   always_comb begin
      match_tag = '0;
      for (int j = 0; j < DEPTH; j++)
         if (hit_vec[j]) match_tag = match_tag | slot_tag[j];
   end
   assign match = |hit_vec;

   // lowest-numbered empty slot wins
   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int j = DEPTH - 1; j >= 0; j--)
         if (!slot_valid[j]) begin
            free_found = 1'b1;
            free_idx   = SLOT_W'(j);
         end
   end

   for (genvar j = 0; j < DEPTH; j++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_valid[j] <= 1'b0;
            slot_value[j] <= '0;
            slot_tag[j]   <= '0;
         end else if (ins_req && free_found && free_idx == SLOT_W'(j)) begin
            slot_valid[j] <= 1'b1;
            slot_value[j] <= srch_value;
            slot_tag[j]   <= ins_tag;
         end else if (slot_valid[j] && drop_vec[slot_tag[j]]) begin
            slot_valid[j] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dedup_reuse_tracker.sv
module dedup_reuse_tracker
   import dedup_pkg::*;
#(
   parameter int unsigned NUM_PREG  = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned TBL_DEPTH = NUM_PREG,
   localparam int unsigned TAG_W    = $clog2(NUM_PREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lk_valid,
   input  logic [DATA_W-1:0]   lk_value,
   input  logic [TAG_W-1:0]    lk_tag,
   input  logic                map_valid,
   input  logic [TAG_W-1:0]    map_tag,
   input  logic                unmap_valid,
   input  logic [TAG_W-1:0]    unmap_tag,
   output logic                rsp_valid,
   output logic                rsp_hit,
   output logic [TAG_W-1:0]    rsp_tag,
   output logic [NUM_PREG-1:0] free_vec
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   if (TBL_DEPTH < 1 || TBL_DEPTH > NUM_PREG) begin : g_bad_depth
      $error("TBL_DEPTH must lie between 1 and NUM_PREG");
   end
   if (CNT_W < DEDUP_MIN_CNT_W) begin : g_bad_cnt
      $error("CNT_W too small for sharing");
   end
   if (NUM_PREG < DEDUP_MIN_PREGS) begin : g_bad_preg
      $error("NUM_PREG too small");
   end

   logic [NUM_PREG-1:0]            map_hot, unmap_hot, hit_hot, own_hot;
   logic [NUM_PREG-1:0]            kill_vec, drop_vec;
   logic [NUM_PREG-1:0][CNT_W-1:0] cnt_q, cnt_nxt;
   logic                           cam_match, hit, ins_req;
   logic [TAG_W-1:0]               match_tag;
   logic [TBL_DEPTH-1:0]               slot_valid;
   logic [TBL_DEPTH-1:0][DATA_W-1:0]   slot_value;
   logic [TBL_DEPTH-1:0][TAG_W-1:0]    slot_tag;

   assign hit = lk_valid && cam_match;

   for (genvar i = 0; i < NUM_PREG; i++) begin : g_dec
      assign map_hot[i]   = map_valid   && (map_tag   == TAG_W'(i));
      assign unmap_hot[i] = unmap_valid && (unmap_tag == TAG_W'(i));
      assign hit_hot[i]   = hit && (match_tag == TAG_W'(i));
      assign own_hot[i]   = hit && (lk_tag    == TAG_W'(i));
      // a register losing its last use this cycle may not be shared
      assign kill_vec[i]  = unmap_hot[i] && !map_hot[i] && (cnt_q[i] == CNT_W'(1));
      assign drop_vec[i]  = (cnt_nxt[i] == '0) || (cnt_nxt[i] == CNT_W'(CNT_MAX));
   end

   assign ins_req = lk_valid && !cam_match
                    && (cnt_nxt[lk_tag] != '0)
                    && (cnt_nxt[lk_tag] != CNT_W'(CNT_MAX));

   dedup_value_cam #(
      .DEPTH    (TBL_DEPTH),
      .DATA_W   (DATA_W),
      .NUM_PREG (NUM_PREG),
      .TAG_W    (TAG_W)
   ) u_cam (
      .clk        (clk),
      .rst_n      (rst_n),
      .srch_value (lk_value),
      .block_vec  (kill_vec),
      .drop_vec   (drop_vec),
      .ins_req    (ins_req),
      .ins_tag    (lk_tag),
      .match      (cam_match),
      .match_tag  (match_tag),
      .slot_valid (slot_valid),
      .slot_value (slot_value),
      .slot_tag   (slot_tag)
   );

   dedup_ref_counters #(
      .NUM_PREG (NUM_PREG),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_a   (map_hot),
      .inc_b   (hit_hot),
      .dec_a   (unmap_hot),
      .dec_b   (own_hot),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .free_q  (free_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_tag   <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= hit;
         rsp_tag   <= lk_valid ? (hit ? match_tag : lk_tag) : '0;
      end
   end
endmodule

// File: rtl/dedup_reuse_tracker_chk.sv
module dedup_reuse_tracker_chk #(
   parameter int unsigned NUM_PREG  = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned TBL_DEPTH = 16,
   parameter int unsigned TAG_W     = 4
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               lk_valid,
   input logic [TAG_W-1:0]                   lk_tag,
   input logic                               rsp_valid,
   input logic                               rsp_hit,
   input logic [TAG_W-1:0]                   rsp_tag,
   input logic [NUM_PREG-1:0]                free_vec,
   input logic [NUM_PREG-1:0][CNT_W-1:0]     cnt_q,
   input logic [TBL_DEPTH-1:0]               slot_valid,
   input logic [TBL_DEPTH-1:0][DATA_W-1:0]   slot_value,
   input logic [TBL_DEPTH-1:0][TAG_W-1:0]    slot_tag
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   // R1: a hit is only reported together with a response, one cycle after a lookup
   p_hit_in_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
   p_rsp_follows_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(lk_valid));

   // R2: a miss hands back the lookup's own tag
   p_miss_own_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_tag == $past(lk_tag));

   // R5: a free pulse is only raised for a register whose count is now zero
   for (genvar i = 0; i < NUM_PREG; i++) begin : g_free
      p_free_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         free_vec[i] |-> cnt_q[i] == '0);
   end

   // R6 and R7: every recorded entry belongs to a live, unsaturated register
   for (genvar j = 0; j < TBL_DEPTH; j++) begin : g_live
      p_entry_live_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
         slot_valid[j] |-> (cnt_q[slot_tag[j]] != '0
                            && cnt_q[slot_tag[j]] != CNT_W'(CNT_MAX)));
   end

   // R10: no value sits in two slots
   for (genvar j = 0; j < TBL_DEPTH; j++) begin : g_uq_a
      for (genvar k = j + 1; k < TBL_DEPTH; k++) begin : g_uq_b
         p_value_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[j] && slot_valid[k]) |-> slot_value[j] != slot_value[k]);
      end
   end
endmodule

bind dedup_reuse_tracker dedup_reuse_tracker_chk #(
   .NUM_PREG  (NUM_PREG),
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W),
   .TBL_DEPTH (TBL_DEPTH),
   .TAG_W     (TAG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_tag     (lk_tag),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_tag    (rsp_tag),
   .free_vec   (free_vec),
   .cnt_q      (cnt_q),
   .slot_valid (slot_valid),
   .slot_value (slot_value),
   .slot_tag   (slot_tag)
);

// File: tb/dedup_reuse_tracker_test.sv
module dedup_reuse_tracker_test;
   localparam int NP   = 16;
   localparam int DW   = 32;
   localparam int CW   = 3;
   localparam int TD   = 4;
   localparam int TW   = 4;
   localparam int CMAX = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [DW-1:0] lk_value = '0;
   logic [TW-1:0] lk_tag = '0;
   logic          map_valid = 1'b0;
   logic [TW-1:0] map_tag = '0;
   logic          unmap_valid = 1'b0;
   logic [TW-1:0] unmap_tag = '0;
   logic          rsp_valid, rsp_hit;
   logic [TW-1:0] rsp_tag;
   logic [NP-1:0] free_vec;

   always #5 clk = ~clk;

   dedup_reuse_tracker #(
      .NUM_PREG (NP), .DATA_W (DW), .CNT_W (CW), .TBL_DEPTH (TD)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .lk_valid (lk_valid), .lk_value (lk_value), .lk_tag (lk_tag),
      .map_valid (map_valid), .map_tag (map_tag),
      .unmap_valid (unmap_valid), .unmap_tag (unmap_tag),
      .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_tag (rsp_tag),
      .free_vec (free_vec)
   );

   int checks = 0;
   int errors = 0;
   int cnt[NP];
   int tbl[logic [DW-1:0]];

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // one clock of stimulus; model stepped alongside, outputs compared one edge later
   task automatic step(bit lv, int val, int lt, bit mv, int mt, bit uv, int ut, string req);
      int killed;
      bit hit;
      int e;
      int s;
      int nx[NP];
      logic [NP-1:0] fr;
      int sz;
      logic [DW-1:0] key;
      logic [DW-1:0] dead[$];
      key = DW'(val);
      lk_valid = lv; lk_value = key; lk_tag = TW'(lt);
      map_valid = mv; map_tag = TW'(mt);
      unmap_valid = uv; unmap_tag = TW'(ut);
      killed = -1;
      if (uv && !(mv && mt == ut) && cnt[ut] == 1) killed = ut;
      hit = lv && tbl.exists(key) && tbl[key] != killed;
      e = hit ? tbl[key] : -1;
      for (int i = 0; i < NP; i++) begin
         s = cnt[i] + int'(mv && mt == i) + int'(hit && e == i)
                    - int'(uv && ut == i) - int'(hit && lt == i);
         if (s < 0) s = 0;
         if (s > CMAX) s = CMAX;
         fr[i] = (cnt[i] > 0) && (s == 0);
         nx[i] = s;
      end
      sz = tbl.size();
      foreach (tbl[k]) if (nx[tbl[k]] == 0 || nx[tbl[k]] == CMAX) dead.push_back(k);
      foreach (dead[d]) tbl.delete(dead[d]);
      if (lv && !hit && nx[lt] > 0 && nx[lt] < CMAX && sz < TD) tbl[key] = lt;
      for (int i = 0; i < NP; i++) cnt[i] = nx[i];
      @(posedge clk);
      @(negedge clk);
      check(req, "rsp_valid", longint'(rsp_valid), longint'(lv));
      check(req, "rsp_hit", longint'(rsp_hit), longint'(hit));
      check(req, "rsp_tag", longint'(rsp_tag), lv ? (hit ? longint'(e) : longint'(lt)) : 0);
      check(req, "free_vec", longint'(free_vec), longint'(fr));
   endtask

   task automatic idle(string req);
      step(0, 0, 0, 0, 0, 0, 0, req);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NP; i++) cnt[i] = 0;
      repeat (3) @(negedge clk);
      // R9: outputs idle while reset is held
      check("R9", "rsp_valid", longint'(rsp_valid), 0);
      check("R9", "rsp_hit", longint'(rsp_hit), 0);
      check("R9", "rsp_tag", longint'(rsp_tag), 0);
      check("R9", "free_vec", longint'(free_vec), 0);
      rst_n = 1'b1;
      idle("R9");

      // R2: map tag 1, then record 0x10 under it
      step(0, 0, 0, 1, 1, 0, 0, "R4");
      step(1, 'h10, 1, 0, 0, 0, 0, "R2");
      // R1: a second producer of 0x10 shares tag 1 and gives back tag 2 (R5)
      step(0, 0, 0, 1, 2, 0, 0, "R4");
      step(1, 'h10, 2, 0, 0, 0, 0, "R1");
      idle("R5");
      // R4: a hit with an unmapped own tag clamps at zero, no pulse
      step(1, 'h10, 5, 0, 0, 0, 0, "R4");
      // R6: release tag 1 down to zero, then 0x10 misses
      step(0, 0, 0, 0, 0, 1, 1, "R4");
      step(0, 0, 0, 0, 0, 1, 1, "R4");
      step(0, 0, 0, 0, 0, 1, 1, "R5");
      step(0, 0, 0, 1, 3, 0, 0, "R4");
      step(1, 'h10, 3, 0, 0, 0, 0, "R6");
      // R7: push tag 3 to the ceiling, then 0x10 no longer hits
      for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 3, 0, 0, "R7");
      step(0, 0, 0, 1, 4, 0, 0, "R4");
      step(1, 'h10, 4, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 3, 0, 0, "R7");
      // R3: fill the table, then a new value is not recorded
      for (int k = 5; k <= 9; k++) step(0, 0, 0, 1, k, 0, 0, "R4");
      step(1, 'h20, 5, 0, 0, 0, 0, "R2");
      step(1, 'h30, 6, 0, 0, 0, 0, "R2");
      step(1, 'h40, 7, 0, 0, 0, 0, "R2");
      step(1, 'h50, 8, 0, 0, 0, 0, "R3");
      step(1, 'h50, 9, 0, 0, 0, 0, "R3");
      step(1, 'h20, 9, 0, 0, 0, 0, "R1");
      // R8: same-cycle last release of tag 6 blocks the 0x30 hit
      step(0, 0, 0, 1, 10, 0, 0, "R4");
      step(1, 'h30, 10, 0, 0, 1, 6, "R8");
      step(0, 0, 0, 1, 11, 0, 0, "R4");
      step(1, 'h30, 11, 0, 0, 0, 0, "R8");
      step(1, 'h30, 10, 0, 0, 0, 0, "R1");

      // R10: random mix of lookups, maps and releases on a small value set
      for (int k = 0; k < 3000; k++) begin
         step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, NP - 1)),
              bit'($urandom_range(0, 1)), int'($urandom_range(0, NP - 1)),
              bit'($urandom_range(0, 2) == 0), int'($urandom_range(0, NP - 1)), "R10");
      end
      idle("R10");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule